// File: doc/BRIEF.md
# Maskable Multi-Source Interrupt Aggregator

This block collects a set of asynchronous interrupt request lines (32 by default) and folds them into one interrupt output for a processor. Each request line is brought into the clock domain through a synchroniser. It is then judged against its own trigger rule: level or edge, active-high/rising or active-low/falling. Qualifying events are latched as pending. The output is raised whenever a pending source is also enabled.

Software drives the block through a plain single-cycle register bus with a 4 KiB byte address space. A write strobe, byte address and write data are sampled on the clock edge. Read data is a combinational function of the address, so it is valid in the same cycle. The interface has no back-pressure: every write completes in the cycle it is presented and every read is answered at once.

The register words used by the block are word-aligned at the following byte offsets. 0x10 holds the per-source polarity. 0x04 holds the enable mask. 0x0C holds the per-source trigger type. 0x08 is the acknowledge word, which is write-only and write-one-to-clear. 0x00 is the read-only masked status. Bring-up software usually writes enable 0, acknowledge all ones, trigger type 0 and polarity all ones.

Top module: `irqc_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The enable (0x04), trigger-type (0x0C) and polarity (0x10) words read back the last value written. The acknowledge word (0x08) always reads 0. Any other offset reads 0. An address with bits [1:0] not equal to 0 reads 0, and a write to such an address has no effect.
- R3: The status word (0x00) equals pending AND enable, so a disabled source never shows in it. `irq_o` is 1 exactly when the status word is non-zero.
- R4: A source with trigger-type bit 0 and polarity bit 0 becomes pending while its input is high. It stays pending after the input falls until it is acknowledged.
- R5: A source with trigger-type bit 0 and polarity bit 1 becomes pending while its input is low. It stays pending until it is acknowledged.
- R6: A source with trigger-type bit 1 and polarity bit 0 becomes pending on a 0-to-1 transition only. An input held high after an acknowledge does not set it again.
- R7: A source with trigger-type bit 1 and polarity bit 1 becomes pending on a 1-to-0 transition only.
- R8: Writing 1 to a bit of the acknowledge word clears that source's pending state at that clock edge. Writing 0 to a bit leaves that source unchanged.
- R9: A level-triggered source that is acknowledged while its input is still active remains pending, because the set from the next sample takes precedence over the clear.
- R10: Sources latch events regardless of the enable mask. A latched event appears in status when the source is enabled. It can be removed by an acknowledge made while the source is disabled.
- R11: A change on a request input reaches the status word on the third rising clock edge after the change, through two synchroniser flops and the pending latch, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Raw interrupt request lines, asynchronous |
| bus_we | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The assertions check several rules on every cycle. The status readback never shows a bit whose enable is clear. The acknowledge word always reads zero. An enable write is visible on the next cycle. An active level always leaves its source pending on the following edge, whether or not an acknowledge was written. An edge source with neither an event nor an acknowledge holds its pending bit unchanged.

Other behaviour only the bench scenarios can show. These include the exact three-edge latency from a pin to status, the choice between the four trigger rules, latching while a source is disabled, and the one-shot nature of an edge against a held input. The bench sweeps every source under all four trigger/polarity combinations to cover them.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  // Word indices (byte offset / 4) of the register file.
  localparam int unsigned WIDX_STATUS = 0;
  localparam int unsigned WIDX_ENABLE = 1;
  localparam int unsigned WIDX_ACK    = 2;
  localparam int unsigned WIDX_TTYPE  = 3;
  localparam int unsigned WIDX_POL    = 4;
endpackage

// File: rtl/irqc_sync.sv
`timescale 1ns/1ps
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
`timescale 1ns/1ps
module irqc_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] smp_i,   // synchronised request lines
  input  logic [WIDTH-1:0] ttype_i, // 1 = edge, 0 = level
  input  logic [WIDTH-1:0] pol_i,   // 1 = low / falling
  input  logic [WIDTH-1:0] ack_i,   // one-cycle clear pulses
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= smp_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_src
    logic active, was_active, event_hit, set_now;
    assign active     = smp_i[i] ^ pol_i[i];
    assign was_active = prev_q[i] ^ pol_i[i];
    assign event_hit  = active & ~was_active;
    assign set_now    = ttype_i[i] ? event_hit : active;

    // Set takes precedence over clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q[i] <= 1'b0;
      else if (set_now)  pend_q[i] <= 1'b1;
      else if (ack_i[i]) pend_q[i] <= 1'b0;
    end

    AST_LEVEL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ttype_i[i] && (smp_i[i] != pol_i[i])) |=> pend_o[i]); // R9
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ttype_i[i] && !ack_i[i] && (smp_i[i] == prev_q[i])) |=> $stable(pend_o[i])); // R6
    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ttype_i[i] && ack_i[i] && (smp_i[i] == prev_q[i])) |=> !pend_o[i]); // R8
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pend_i,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  status_o,
  output logic [WIDTH-1:0]  ttype_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  ack_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_en, wr_ttype, wr_pol, wr_ack;
  logic [WIDTH-1:0]  en_q, ttype_q, pol_q;

  assign word     = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_en    = bus_we && aligned && (word == WORD_W'(WIDX_ENABLE));
  assign wr_ttype = bus_we && aligned && (word == WORD_W'(WIDX_TTYPE));
  assign wr_pol   = bus_we && aligned && (word == WORD_W'(WIDX_POL));
  assign wr_ack   = bus_we && aligned && (word == WORD_W'(WIDX_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      ttype_q <= '0;
      pol_q   <= '0;
    end else begin
      if (wr_en)    en_q    <= bus_wdata;
      if (wr_ttype) ttype_q <= bus_wdata;
      if (wr_pol)   pol_q   <= bus_wdata;
    end
  end

  assign ack_o    = wr_ack ? bus_wdata : '0;
  assign status_o = pend_i & en_q;
  assign ttype_o  = ttype_q;
  assign pol_o    = pol_q;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        WORD_W'(WIDX_STATUS): bus_rdata = status_o;
        WORD_W'(WIDX_ENABLE): bus_rdata = en_q;
        WORD_W'(WIDX_TTYPE):  bus_rdata = ttype_q;
        WORD_W'(WIDX_POL):    bus_rdata = pol_q;
        default:              bus_rdata = '0;
      endcase
    end
  end

  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && word == WORD_W'(WIDX_STATUS)) |-> ((bus_rdata & ~en_q) == '0)); // R3
  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WORD_W'(WIDX_ACK)) |-> (bus_rdata == '0)); // R2
  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata))); // R2
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] smp, pend, status, ttype, pol, ack;

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_src), .q_o(smp)
  );

  irqc_detect #(.WIDTH(NUM_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .ttype_i(ttype), .pol_i(pol),
    .ack_i(ack), .pend_o(pend)
  );

  irqc_regs #(.WIDTH(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend_i(pend), .bus_rdata(bus_rdata),
    .status_o(status), .ttype_o(ttype), .pol_o(pol), .ack_o(ack)
  );

  assign irq_o = |status;

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend != '0)); // R3
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
  localparam int N = 32;
  localparam logic [11:0] A_STAT = 12'h000, A_EN = 12'h004, A_ACK = 12'h008,
                          A_TT = 12'h00C, A_POL = 12'h010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [11:0] a, input logic [N-1:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] idle, bit_b, tt_v, pol_v;
    string req_tr;
    bit is_edge;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    chk_rd("R1", A_STAT, '0); chk_rd("R1", A_EN, '0); chk_rd("R1", A_ACK, '0);
    chk_rd("R1", A_TT, '0);   chk_rd("R1", A_POL, '0);
    chk("R1", {31'b0, irq_o}, '0);

    // R2: readback, write-only ack, unmapped and misaligned addresses
    wr(A_EN, 32'hA5C3_0F96);  chk_rd("R2", A_EN, 32'hA5C3_0F96);
    wr(A_TT, 32'h1234_8765);  chk_rd("R2", A_TT, 32'h1234_8765);
    wr(A_POL, 32'hFEDC_0011); chk_rd("R2", A_POL, 32'hFEDC_0011);
    wr(A_ACK, '1);            chk_rd("R2", A_ACK, '0);
    chk_rd("R2", 12'h014, '0); chk_rd("R2", 12'hFFC, '0); chk_rd("R2", 12'h005, '0);
    wr(12'h005, 32'h0000_FFFF); chk_rd("R2", A_EN, 32'hA5C3_0F96);
    wr(A_EN, '0); wr(A_TT, '0); wr(A_POL, '0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      is_edge = cfg[1];
      tt_v  = cfg[1] ? '1 : '0;
      pol_v = cfg[0] ? '1 : '0;
      idle  = pol_v;
      case (cfg)
        0: req_tr = "R4";
        1: req_tr = "R5";
        2: req_tr = "R6";
        default: req_tr = "R7";
      endcase
      for (int b = 0; b < N; b++) begin
        bit_b = N'(1) << b;
        wr(A_EN, '0); src = idle;
        wr(A_TT, tt_v); wr(A_POL, pol_v);
        step(4);
        wr(A_ACK, '1); wr(A_EN, '1);
        chk_rd("R8", A_STAT, '0);

        // assert source; latency and trigger rule
        src = idle ^ bit_b;
        step(2); chk_rd("R11", A_STAT, '0);
        step(1); chk_rd(req_tr, A_STAT, bit_b);
        chk("R3", {31'b0, irq_o}, 32'd1);

        // release; stays latched
        src = idle;
        step(4); chk_rd(req_tr, A_STAT, bit_b);

        // ack with zero in this bit: no effect; then one: clears
        wr(A_ACK, ~bit_b); chk_rd("R8", A_STAT, bit_b);
        wr(A_ACK, bit_b);  chk_rd("R8", A_STAT, '0);
        chk("R3", {31'b0, irq_o}, '0);

        // ack while input still active
        src = idle ^ bit_b;
        step(4); chk_rd(req_tr, A_STAT, bit_b);
        wr(A_ACK, bit_b);
        step(3);
        if (is_edge) chk_rd("R6", A_STAT, '0);
        else         chk_rd("R9", A_STAT, bit_b);
        src = idle;
        step(4); wr(A_ACK, '1); chk_rd("R8", A_STAT, '0);

        // latching while disabled
        wr(A_EN, ~bit_b);
        src = idle ^ bit_b; step(4);
        src = idle;         step(4);
        chk_rd("R3", A_STAT, '0);
        chk("R3", {31'b0, irq_o}, '0);
        wr(A_EN, '1); chk_rd("R10", A_STAT, bit_b);
        wr(A_EN, ~bit_b); wr(A_ACK, bit_b); wr(A_EN, '1);
        chk_rd("R10", A_STAT, '0);
      end
    end
    finish_run();
  end
endmodule